// File: doc/BRIEF.md
# Pixel Hit Edge Timestamp Capture

This block is the digital hit-time logic that sits behind one pixel's discriminator. A shared Gray-coded time bus runs down the column and advances once per tick of an external reference clock. A nominal 40 MHz tick gives 25 ns per count. The block records the bus value when the discriminator output goes high, which gives the arrival time. It records the bus value again when the output goes low. It then holds both codes and raises a token toward the column readout.

The discriminator output is asynchronous to the readout clock, so it first passes through a synchroniser. Edges are then found on the synchronised level. Once a hit is complete, the pixel ignores the discriminator until the readout pulses a read/clear strobe. A small helper converts both stored codes to binary. It also forms the time over threshold as the trailing count minus the leading count, modulo the bus width, so a counter wrap between the two edges still yields the true duration.

Top module: `pix_edge_stamp`

## Requirements
- R1: After a synchronous reset, hit_tok is 0, and lead_gray, trail_gray, lead_bin, trail_bin and tot are all 0.
- R2: With the default two-stage synchroniser, a rise of comp_in that is first sampled at clock edge k loads lead_gray with the value of ts_gray at edge k+2. This happens only when no hit is held and no capture is in progress.
- R3: A fall of comp_in while a capture is in progress loads trail_gray with ts_gray, using the same three-edge timing as R2. At that same edge hit_tok goes to 1.
- R4: Between the leading capture and the trailing capture, hit_tok stays 0.
- R5: While hit_tok is 1 and rd_clr is 0, further rises and falls of comp_in have no effect: hit_tok, lead_gray and trail_gray keep their values.
- R6: rd_clr sampled high at a clock edge clears hit_tok, lead_gray and trail_gray to 0 at that edge and returns the block to idle, whatever state it was in. It wins over any edge seen in the same cycle. A fall of comp_in seen while idle is ignored.
- R7: lead_bin and trail_bin are the binary values of lead_gray and trail_gray. The most significant bit is copied, and each lower bit is the XOR of the binary bit above it and the Gray bit in its own position.
- R8: tot equals (trail_bin - lead_bin) mod 2^TS_W, including when the count wrapped between the two edges (for example, 250 to 5 gives 11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst | input | 1 | Synchronous active-high reset |
| comp_in | input | 1 | Asynchronous discriminator output |
| ts_gray | input | TS_W | Shared Gray-coded column time bus |
| rd_clr | input | 1 | Read/clear strobe from the column readout |
| hit_tok | output | 1 | Hit flag / token request, registered |
| lead_gray | output | TS_W | Stored leading-edge Gray code |
| trail_gray | output | TS_W | Stored trailing-edge Gray code |
| lead_bin | output | TS_W | Leading stamp in binary |
| trail_bin | output | TS_W | Trailing stamp in binary |
| tot | output | TS_W | Time over threshold, modulo 2^TS_W |

## Verification
The bench goes after the wrap case (250 to 5), the full-range case (0 to 255) and the zero-width case where both stamps are equal. A subtractor that is not modulo, or a bad Gray decode, would give wrong tot or binary values in these cases. It drives a second discriminator pulse while a hit is still held. A design that re-arms without a clear would overwrite the stamps or raise a second token. It also aborts an open capture with the clear strobe and then releases the discriminator. A design that still honoured that stray fall would raise a token with no leading stamp behind it. During the open capture it checks that the token stays low, which catches a design that flags the hit on the leading edge.

// File: rtl/pix_stamp_pkg.sv
package pix_stamp_pkg;
  localparam int unsigned TS_W_DEF = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_HELD  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/pix_sync2.sv
module pix_sync2 #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

  // R2
  sync_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (chain[0] == $past(d)));
endmodule

// File: rtl/pix_edge_capture.sv
module pix_edge_capture
  import pix_stamp_pkg::*;
#(
  parameter int unsigned TS_W = TS_W_DEF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic [TS_W-1:0] ts_gray,
  input  logic            rd_clr,
  output logic [TS_W-1:0] lead_q,
  output logic [TS_W-1:0] trail_q,
  output logic            hit_q
);
  cap_state_e st;
  logic       lvl_d;
  logic       rise, fall;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  always_ff @(posedge clk) begin
    if (rst || rd_clr) begin
      st      <= ST_IDLE;
      lead_q  <= '0;
      trail_q <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (rise) begin
          lead_q <= ts_gray;
          st     <= ST_ARMED;
        end
        ST_ARMED: if (fall) begin
          trail_q <= ts_gray;
          hit_q   <= 1'b1;
          st      <= ST_HELD;
        end
        ST_HELD: ;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  tok_on_trail_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hit_q) |-> ($past(fall) && $past(st == ST_ARMED)));

  // R4
  no_tok_early_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_HELD) |-> !hit_q);

  // R5
  held_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_q && !rd_clr) |=> (hit_q && $stable(lead_q) && $stable(trail_q)));

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clr |=> (!hit_q && lead_q == '0 && trail_q == '0));
endmodule

// File: rtl/pix_tot_calc.sv
module pix_tot_calc #(
  parameter int unsigned TS_W = 8
) (
  input  logic [TS_W-1:0] lead_g,
  input  logic [TS_W-1:0] trail_g,
  output logic [TS_W-1:0] lead_b,
  output logic [TS_W-1:0] trail_b,
  output logic [TS_W-1:0] tot
);
  function automatic logic [TS_W-1:0] g2b(input logic [TS_W-1:0] g);
    logic [TS_W-1:0] b;
    b[TS_W-1] = g[TS_W-1];
    for (int i = int'(TS_W) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_comb begin
    lead_b  = g2b(lead_g);
    trail_b = g2b(trail_g);
    tot     = trail_b - lead_b;
  end

  // R7
  always_comb begin
    gray_inv_chk: assert (((lead_b ^ (lead_b >> 1)) == lead_g) &&
                          ((trail_b ^ (trail_b >> 1)) == trail_g));
  end
endmodule

// File: rtl/pix_edge_stamp.sv
module pix_edge_stamp
  import pix_stamp_pkg::*;
#(
  parameter int unsigned TS_W        = TS_W_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            comp_in,
  input  logic [TS_W-1:0] ts_gray,
  input  logic            rd_clr,
  output logic            hit_tok,
  output logic [TS_W-1:0] lead_gray,
  output logic [TS_W-1:0] trail_gray,
  output logic [TS_W-1:0] lead_bin,
  output logic [TS_W-1:0] trail_bin,
  output logic [TS_W-1:0] tot
);
  logic comp_s;

  pix_sync2 #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (comp_in),
    .q   (comp_s)
  );

  pix_edge_capture #(.TS_W(TS_W)) i_cap (
    .clk     (clk),
    .rst     (rst),
    .lvl     (comp_s),
    .ts_gray (ts_gray),
    .rd_clr  (rd_clr),
    .lead_q  (lead_gray),
    .trail_q (trail_gray),
    .hit_q   (hit_tok)
  );

  pix_tot_calc #(.TS_W(TS_W)) i_tot (
    .lead_g  (lead_gray),
    .trail_g (trail_gray),
    .lead_b  (lead_bin),
    .trail_b (trail_bin),
    .tot     (tot)
  );

  // R8
  tot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    hit_tok |-> ((lead_bin + tot) == trail_bin));
endmodule

// File: tb/test_pix_edge_stamp.sv
module test_pix_edge_stamp;
  logic       clk = 1'b0;
  logic       rst, comp_in, rd_clr;
  logic [7:0] ts_gray;
  logic       hit_tok;
  logic [7:0] lead_gray, trail_gray, lead_bin, trail_bin, tot;

  always #2 clk = ~clk;

  pix_edge_stamp i_pix_edge_stamp (
    .clk(clk), .rst(rst), .comp_in(comp_in), .ts_gray(ts_gray), .rd_clr(rd_clr),
    .hit_tok(hit_tok), .lead_gray(lead_gray), .trail_gray(trail_gray),
    .lead_bin(lead_bin), .trail_bin(trail_bin), .tot(tot)
  );

  typedef struct packed {
    logic [7:0] lg, tg, lb, tb, tt;
  } exp_t;
  exp_t sb_q[$];

  int n_run = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [7:0] to_g(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] lb, input logic [7:0] tb);
    exp_t e;
    e.lg = to_g(lb); e.tg = to_g(tb); e.lb = lb; e.tb = tb; e.tt = tb - lb;
    sb_q.push_back(e);
    ts_gray = to_g(lb);
    comp_in = 1'b1;
    tick(4);
    chk("R2", "lead_gray", lead_gray, to_g(lb));
    chk("R4", "hit_tok armed", hit_tok, 0);
    ts_gray = to_g(tb);
    tick(1);
    comp_in = 1'b0;
    tick(4);
    chk("R3", "hit_tok", hit_tok, 1);
  endtask

  task automatic clear_chk(input string req);
    rd_clr = 1'b1;
    tick(1);
    rd_clr = 1'b0;
    chk(req, "hit_tok cleared", hit_tok, 0);
    chk(req, "lead cleared", lead_gray, 0);
    chk(req, "trail cleared", trail_gray, 0);
  endtask

  // monitor: pops one expected item per token rise
  logic hit_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && hit_tok && !hit_prev) begin
      if (sb_q.size() == 0) begin
        chk("R5", "unexpected token", 1, 0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R2", "mon lead_gray", lead_gray, e.lg);
        chk("R3", "mon trail_gray", trail_gray, e.tg);
        chk("R7", "lead_bin", lead_bin, e.lb);
        chk("R7", "trail_bin", trail_bin, e.tb);
        chk("R8", "tot", tot, e.tt);
      end
    end
    hit_prev = hit_tok;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; comp_in = 1'b0; rd_clr = 1'b0; ts_gray = '0;
    tick(3);
    rst = 1'b0;
    tick(1);
    chk("R1", "hit_tok", hit_tok, 0);
    chk("R1", "lead_gray", lead_gray, 0);
    chk("R1", "trail_gray", trail_gray, 0);
    chk("R1", "tot", tot, 0);

    pulse(8'd10, 8'd37);
    clear_chk("R6");
    pulse(8'd250, 8'd5);   // R8 wrap
    clear_chk("R6");
    pulse(8'd0, 8'd255);
    clear_chk("R6");
    pulse(8'd77, 8'd77);   // R8 zero width

    // R5: second pulse while held is ignored
    ts_gray = to_g(8'd200);
    comp_in = 1'b1;
    tick(5);
    comp_in = 1'b0;
    tick(5);
    chk("R5", "hit held", hit_tok, 1);
    chk("R5", "lead kept", lead_gray, to_g(8'd77));
    chk("R5", "trail kept", trail_gray, to_g(8'd77));
    chk("R5", "tot kept", tot, 0);
    clear_chk("R6");

    // R6: abort open capture, then the fall is ignored in idle
    ts_gray = to_g(8'd9);
    comp_in = 1'b1;
    tick(4);
    chk("R2", "lead before abort", lead_gray, to_g(8'd9));
    clear_chk("R6");
    comp_in = 1'b0;
    tick(5);
    chk("R6", "no token after idle fall", hit_tok, 0);
    chk("R6", "trail stays 0", trail_gray, 0);

    pulse(8'd128, 8'd129);
    clear_chk("R6");
    tick(2);
    chk("R3", "scoreboard drained", sb_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule